// File: doc/BRIEF.md
# Real-Time-Clock Host Register File

This block is the host side of a real-time-clock device. A host reaches a 128-byte register space through two byte-wide ports: a write to the even port selects a register index, and accesses to the odd port read or write the selected register. Four of these indices are control registers: a rate/oscillator register with an update-in-progress bit, a mode register holding the enables and format bits, a flag register, and a constant validity register. All other indices are plain storage bytes. These include the alarm bytes that the block compares against the live time.

Sibling blocks supply three pulses: a periodic tick from the rate divider, an update-begin and an update-done from the timekeeper. They also supply the current seconds, minutes and hours bytes. The block drives the control bits back to those siblings. It collects interrupt causes into the flag register and drives one level interrupt line. Reading the flag register clears the flags and releases the line.

Top module: `clock_regfile`

## Requirements
- R1: A write with `bus_addr`=0 stores `bus_wdata[6:0]` as the index (bit 7 is dropped). A write with `bus_addr`=1 writes the indexed register. A read with `bus_addr`=0 returns 0xFF.
- R2: After reset, index 10 reads 0x26, index 11 reads 0x02, index 12 reads 0x00, index 13 reads 0x80, and `irq` is low.
- R3: Index 12 is the flag register: bit 7 is the interrupt summary, bit 6 is the periodic flag, bit 5 is the alarm flag, bit 4 is the update flag, and bits 3:0 are 0. A data-port read of index 12 returns the current value. From the next cycle the register holds 0x00 and `irq` is low, unless a new event arrives in that same cycle.
- R4: Writes to index 12 and index 13 have no effect.
- R5: Bit 7 of index 10 is the update-in-progress bit. It is set by `upd_begin` when bit 7 of index 11 is 0, cleared by `upd_done`, and kept unchanged by a host write to index 10, which replaces only bits 6:0.
- R6: A write to index 11 with bit 7 high clears the update-in-progress bit and stores bit 4 of index 11 as 0.
- R7: Alarm bytes sit at index 1 (seconds), index 3 (minutes) and index 5 (hours). Each byte matches when its bits 7:6 are both 1, or when it equals `cur_sec`, `cur_min` or `cur_hour` respectively. On `upd_done` with all three matching and bit 5 of index 11 set, flag bits 5 and 7 are set and `irq` rises.
- R8: Every `upd_done` sets flag bit 4. Flag bit 7 and `irq` are set only when bit 4 of index 11 is 1.
- R9: A `tick_periodic` pulse while bit 6 of index 11 is 1 sets flag bits 6 and 7 and raises `irq`. A pulse while bit 6 is 0 changes nothing.
- R10: `irq` stays high from the first qualifying event until index 12 is read. An event in the same cycle as that read appears in the flag register and on `irq` for the next read.
- R11: Every index other than 10 to 13 reads back the last byte written to it.
- R12: The control outputs follow the stored registers. `rate_sel` is index 10 bits 3:0 and `osc_sel` is index 10 bits 6:4. From index 11: bit 7 is `hold_set`, bit 6 is `per_ie`, bit 5 is `alm_ie`, bit 4 is `upd_ie`, bit 3 is `sqw_en`, bit 2 is `bin_mode` and bit 1 is `hr24`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe (a data-port read of index 12 clears the flags) |
| bus_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational) |
| tick_periodic | input | 1 | Periodic tick pulse from the divider |
| upd_begin | input | 1 | Update-begin pulse from the timekeeper |
| upd_done | input | 1 | Update-done pulse from the timekeeper |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| rate_sel | output | 4 | Periodic rate select |
| osc_sel | output | 3 | Oscillator control field |
| hold_set | output | 1 | Time-set hold bit |
| per_ie | output | 1 | Periodic interrupt enable |
| alm_ie | output | 1 | Alarm interrupt enable |
| upd_ie | output | 1 | Update interrupt enable |
| sqw_en | output | 1 | Square-wave enable |
| bin_mode | output | 1 | Binary (not BCD) data mode |
| hr24 | output | 1 | 24-hour format |
| irq | output | 1 | Level interrupt request |

## Verification
A bad flag bit or a bad interrupt latch shows on `irq` one cycle after the event that caused it. It also shows on the very next read of index 12, where the pattern reveals which cause was lost or invented. A bad update-in-progress bit or a bad mode bit is visible at once on the control outputs, and on the next data-port read of index 10 or 11. A read-clear that drops an event arriving in the same cycle shows only on the second read of index 12, so the bench reads twice around such collisions.

// File: rtl/rtcr_pkg.sv
package rtcr_pkg;
  localparam int BYTE_W = 8;
  localparam int IX_ALM_SEC  = 1;
  localparam int IX_ALM_MIN  = 3;
  localparam int IX_ALM_HOUR = 5;
  localparam int IX_RATE  = 10;
  localparam int IX_MODE  = 11;
  localparam int IX_FLAG  = 12;
  localparam int IX_VALID = 13;

  localparam logic [BYTE_W-1:0] RATE_RST  = 8'h26;
  localparam logic [BYTE_W-1:0] MODE_RST  = 8'h02;
  localparam logic [BYTE_W-1:0] VALID_VAL = 8'h80;

  // flag register bit positions (R3)
  localparam int FB_IRQ = 7;
  localparam int FB_PER = 6;
  localparam int FB_ALM = 5;
  localparam int FB_UPD = 4;

  // alarm field compare with the two-top-bits wildcard (R7)
  function automatic logic alarm_field_hit(input logic [BYTE_W-1:0] alm,
                                           input logic [BYTE_W-1:0] cur);
    return (alm[7:6] == 2'b11) || (alm == cur);
  endfunction
endpackage

// File: rtl/rtcr_ctl_regs.sv
module rtcr_ctl_regs
  import rtcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rate,
  input  logic              wr_mode,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              upd_begin,
  input  logic              upd_done,
  output logic [6:0]        rate_q,
  output logic              uip_q,
  output logic [BYTE_W-1:0] mode_q
);
  logic set_wr;
  assign set_wr = wr_mode && wdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= RATE_RST[6:0];
      mode_q <= MODE_RST;
    end else begin
      if (wr_rate) rate_q <= wdata[6:0];             // R5: bit 7 kept apart
      if (wr_mode) mode_q <= set_wr ? (wdata & 8'hEF) : wdata; // R6
    end
  end

  // R5/R6: the SET write wins over any update pulse in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)                        uip_q <= 1'b0;
    else if (set_wr || upd_done)       uip_q <= 1'b0;
    else if (upd_begin && !mode_q[7])  uip_q <= 1'b1;
  end
endmodule

// File: rtl/rtcr_alarm_match.sv
module rtcr_alarm_match
  import rtcr_pkg::*;
(
  input  logic [BYTE_W-1:0] alm_sec,
  input  logic [BYTE_W-1:0] alm_min,
  input  logic [BYTE_W-1:0] alm_hour,
  input  logic [BYTE_W-1:0] cur_sec,
  input  logic [BYTE_W-1:0] cur_min,
  input  logic [BYTE_W-1:0] cur_hour,
  output logic              hit
);
  assign hit = alarm_field_hit(alm_sec, cur_sec) &&
               alarm_field_hit(alm_min, cur_min) &&
               alarm_field_hit(alm_hour, cur_hour);
endmodule

// File: rtl/rtcr_irq_flags.sv
module rtcr_irq_flags
  import rtcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_clr,
  input  logic              tick,
  input  logic              upd_done,
  input  logic              alarm_hit,
  input  logic              pie,
  input  logic              aie,
  input  logic              uie,
  output logic [BYTE_W-1:0] flag_q,
  output logic [BYTE_W-1:0] set_mask,
  output logic              irq
);
  logic per_ev, alm_ev, upd_irq_ev, irq_ev;

  assign per_ev     = tick && pie;                    // R9
  assign alm_ev     = upd_done && aie && alarm_hit;   // R7
  assign upd_irq_ev = upd_done && uie;                // R8
  assign irq_ev     = per_ev || alm_ev || upd_irq_ev;

  always_comb begin
    set_mask         = '0;
    set_mask[FB_IRQ] = irq_ev;
    set_mask[FB_PER] = per_ev;
    set_mask[FB_ALM] = alm_ev;
    set_mask[FB_UPD] = upd_done;
  end

  // R10: the read clears first, then same-cycle events are merged in
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      irq    <= 1'b0;
    end else begin
      flag_q <= (rd_clr ? '0 : flag_q) | set_mask;
      irq    <= (rd_clr ? 1'b0 : irq) | irq_ev;
    end
  end
endmodule

// File: rtl/clock_regfile.sv
module clock_regfile
  import rtcr_pkg::*;
#(
  parameter int IDXW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tick_periodic,
  input  logic              upd_begin,
  input  logic              upd_done,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  output logic [3:0]        rate_sel,
  output logic [2:0]        osc_sel,
  output logic              hold_set,
  output logic              per_ie,
  output logic              alm_ie,
  output logic              upd_ie,
  output logic              sqw_en,
  output logic              bin_mode,
  output logic              hr24,
  output logic              irq
);
  localparam int DEPTH = 1 << IDXW;

  logic [IDXW-1:0]   idx_q;
  logic [BYTE_W-1:0] store [DEPTH];
  logic              data_wr, is_rate, is_mode, is_flag, is_valid, is_ctl;
  logic              wr_rate, wr_mode;
  logic              flag_rd_stb, set_wr_stb, alarm_hit;
  logic [6:0]        rate_q;
  logic              uip_q;
  logic [BYTE_W-1:0] mode_q, flag_q, flag_set;

  // R1: index port
  always_ff @(posedge clk) begin
    if (!rst_n)                   idx_q <= '0;
    else if (bus_we && !bus_addr) idx_q <= bus_wdata[IDXW-1:0];
  end

  assign data_wr  = bus_we && bus_addr;
  assign is_rate  = (idx_q == IDXW'(IX_RATE));
  assign is_mode  = (idx_q == IDXW'(IX_MODE));
  assign is_flag  = (idx_q == IDXW'(IX_FLAG));
  assign is_valid = (idx_q == IDXW'(IX_VALID));
  assign is_ctl   = is_rate || is_mode || is_flag || is_valid;
  assign wr_rate  = data_wr && is_rate;
  assign wr_mode  = data_wr && is_mode;
  assign set_wr_stb  = wr_mode && bus_wdata[7];
  assign flag_rd_stb = bus_re && bus_addr && is_flag;

  // R11: plain storage; R4: flag and validity indices never written
  always_ff @(posedge clk) begin
    if (data_wr && !is_ctl) store[idx_q] <= bus_wdata;
  end

  rtcr_ctl_regs u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_rate(wr_rate), .wr_mode(wr_mode),
    .wdata(bus_wdata), .upd_begin(upd_begin), .upd_done(upd_done),
    .rate_q(rate_q), .uip_q(uip_q), .mode_q(mode_q)
  );

  rtcr_alarm_match u_alm (
    .alm_sec(store[IX_ALM_SEC]), .alm_min(store[IX_ALM_MIN]),
    .alm_hour(store[IX_ALM_HOUR]), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .hit(alarm_hit)
  );

  rtcr_irq_flags u_flg (
    .clk(clk), .rst_n(rst_n), .rd_clr(flag_rd_stb), .tick(tick_periodic),
    .upd_done(upd_done), .alarm_hit(alarm_hit), .pie(mode_q[6]),
    .aie(mode_q[5]), .uie(mode_q[4]), .flag_q(flag_q), .set_mask(flag_set),
    .irq(irq)
  );

  // R1/R2/R3: read mux
  always_comb begin
    if (!bus_addr)     bus_rdata = 8'hFF;
    else if (is_rate)  bus_rdata = {uip_q, rate_q};
    else if (is_mode)  bus_rdata = mode_q;
    else if (is_flag)  bus_rdata = flag_q;
    else if (is_valid) bus_rdata = VALID_VAL;
    else               bus_rdata = store[idx_q];
  end

  // R12: control outputs
  assign rate_sel = rate_q[3:0];
  assign osc_sel  = rate_q[6:4];
  assign hold_set = mode_q[7];
  assign per_ie   = mode_q[6];
  assign alm_ie   = mode_q[5];
  assign upd_ie   = mode_q[4];
  assign sqw_en   = mode_q[3];
  assign bin_mode = mode_q[2];
  assign hr24     = mode_q[1];
endmodule

// File: rtl/clock_regfile_chk.sv
module clock_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_re,
  input logic       bus_addr,
  input logic [7:0] bus_rdata,
  input logic       tick_periodic,
  input logic       upd_done,
  input logic       per_ie,
  input logic       upd_ie,
  input logic       irq,
  input logic       flag_rd_stb,
  input logic       set_wr_stb,
  input logic       uip_q,
  input logic [7:0] flag_q,
  input logic [7:0] flag_set
);
  a_r1_index_port_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !bus_addr) |-> (bus_rdata == 8'hFF));

  a_r3_read_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd_stb && flag_set == 8'h00) |=> (flag_q == 8'h00 && !irq));

  a_r3_irq_tracks_summary: assert property (@(posedge clk) disable iff (!rst_n)
    irq == flag_q[7]);

  a_r6_set_clears_uie_uip: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr_stb |=> (!upd_ie && !uip_q));

  a_r8_update_sets_uf: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> flag_q[4]);

  a_r9_periodic_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_periodic && per_ie) |=> (irq && flag_q[6]));

  a_r10_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !flag_rd_stb) |=> irq);
endmodule

bind clock_regfile clock_regfile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_re(bus_re), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .tick_periodic(tick_periodic), .upd_done(upd_done),
  .per_ie(per_ie), .upd_ie(upd_ie), .irq(irq), .flag_rd_stb(flag_rd_stb),
  .set_wr_stb(set_wr_stb), .uip_q(uip_q), .flag_q(flag_q), .flag_set(flag_set)
);

// File: tb/clock_regfile_tb_top.sv
module clock_regfile_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0, bus_re = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic tick_periodic = 1'b0, upd_begin = 1'b0, upd_done = 1'b0;
  logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
  logic [3:0] rate_sel;
  logic [2:0] osc_sel;
  logic hold_set, per_ie, alm_ie, upd_ie, sqw_en, bin_mode, hr24, irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clock_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_periodic(tick_periodic), .upd_begin(upd_begin), .upd_done(upd_done),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .rate_sel(rate_sel), .osc_sel(osc_sel), .hold_set(hold_set),
    .per_ie(per_ie), .alm_ie(alm_ie), .upd_ie(upd_ie), .sqw_en(sqw_en),
    .bin_mode(bin_mode), .hr24(hr24), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end just after a falling edge
  task automatic bus_write(input logic a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] v);
    bus_re = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    bus_write(1'b0, i);
    bus_write(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] v);
    bus_write(1'b0, i);
    bus_read(1'b1, v);
  endtask

  task automatic pulse_tick();
    tick_periodic = 1'b1; @(negedge clk); tick_periodic = 1'b0;
  endtask
  task automatic pulse_begin();
    upd_begin = 1'b1; @(negedge clk); upd_begin = 1'b0;
  endtask
  task automatic pulse_done();
    upd_done = 1'b1; @(negedge clk); upd_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_values();
    logic [7:0] v;
    check("R2 irq after reset", {7'b0, irq}, 8'h00);
    reg_rd(8'd10, v); check("R2 index10", v, 8'h26);
    reg_rd(8'd11, v); check("R2 index11", v, 8'h02);
    reg_rd(8'd12, v); check("R2 index12", v, 8'h00);
    reg_rd(8'd13, v); check("R2 index13", v, 8'h80);
    bus_read(1'b0, v); check("R1 index port read", v, 8'hFF);
  endtask

  task automatic t_storage();
    logic [7:0] v;
    reg_wr(8'h40, 8'h5A);
    reg_wr(8'h7F, 8'hC3);
    reg_wr(8'h00, 8'h17);
    reg_rd(8'h40, v); check("R11 index 0x40", v, 8'h5A);
    reg_rd(8'h7F, v); check("R11 index 0x7F", v, 8'hC3);
    reg_rd(8'h00, v); check("R11 index 0x00", v, 8'h17);
    reg_rd(8'hC0, v); check("R1 index bit7 dropped", v, 8'h5A);
  endtask

  task automatic t_ro_regs();
    logic [7:0] v;
    reg_wr(8'd12, 8'hFF);
    check("R4 irq after flag write", {7'b0, irq}, 8'h00);
    reg_rd(8'd12, v); check("R4 flag write ignored", v, 8'h00);
    reg_wr(8'd13, 8'h00);
    reg_rd(8'd13, v); check("R4 validity write ignored", v, 8'h80);
  endtask

  task automatic t_uip();
    logic [7:0] v;
    pulse_begin();
    reg_rd(8'd10, v); check("R5 UIP set by begin", v, 8'hA6);
    reg_wr(8'd10, 8'h2F);
    reg_rd(8'd10, v); check("R5 write keeps UIP", v, 8'hAF);
    check("R12 rate_sel", {4'b0, rate_sel}, 8'h0F);
    check("R12 osc_sel", {5'b0, osc_sel}, 8'h02);
    pulse_done();
    reg_rd(8'd10, v); check("R5 UIP cleared by done", v, 8'h2F);
    check("R8 no irq without UIE", {7'b0, irq}, 8'h00);
    reg_rd(8'd12, v); check("R8 UF set always", v, 8'h10);
    reg_rd(8'd12, v); check("R3 flags cleared by read", v, 8'h00);
  endtask

  task automatic t_set_mode();
    logic [7:0] v;
    pulse_begin();
    reg_wr(8'd11, 8'h92);
    reg_rd(8'd11, v); check("R6 UIE forced 0", v, 8'h82);
    reg_rd(8'd10, v); check("R6 UIP cleared by SET", v, 8'h2F);
    check("R12 hold_set", {7'b0, hold_set}, 8'h01);
    pulse_begin();
    reg_rd(8'd10, v); check("R5 no UIP while SET", v, 8'h2F);
    pulse_done();
    reg_wr(8'd11, 8'h12);
    reg_rd(8'd11, v); check("R6 UIE kept without SET", v, 8'h12);
    reg_rd(8'd12, v); check("R8 UF only", v, 8'h10);
  endtask

  task automatic t_update_irq();
    logic [7:0] v;
    pulse_done();
    check("R8 irq with UIE", {7'b0, irq}, 8'h01);
    reg_rd(8'd12, v); check("R8 flags UF+IRQF", v, 8'h90);
    check("R3 irq released", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_periodic();
    logic [7:0] v;
    reg_wr(8'd11, 8'h02);
    pulse_tick();
    check("R9 no irq without PIE", {7'b0, irq}, 8'h00);
    reg_rd(8'd12, v); check("R9 no flags without PIE", v, 8'h00);
    reg_wr(8'd11, 8'h42);
    pulse_tick();
    check("R9 irq with PIE", {7'b0, irq}, 8'h01);
    reg_rd(8'd12, v); check("R9 flags PF+IRQF", v, 8'hC0);
  endtask

  task automatic t_alarm();
    logic [7:0] v;
    reg_wr(8'd11, 8'h22);
    reg_wr(8'd1, 8'h30);
    reg_wr(8'd3, 8'hC5);
    reg_wr(8'd5, 8'h12);
    cur_sec = 8'h30; cur_min = 8'h07; cur_hour = 8'h12;
    pulse_done();
    check("R7 irq on match", {7'b0, irq}, 8'h01);
    reg_rd(8'd12, v); check("R7 flags AF+IRQF+UF", v, 8'hB0);
    cur_hour = 8'h13;
    pulse_done();
    check("R7 no irq on hour miss", {7'b0, irq}, 8'h00);
    reg_rd(8'd12, v); check("R7 UF only on miss", v, 8'h10);
    reg_wr(8'd1, 8'hFF);
    reg_wr(8'd5, 8'hC0);
    pulse_done();
    reg_rd(8'd12, v); check("R7 all wildcard match", v, 8'hB0);
  endtask

  task automatic t_hold_and_collide();
    logic [7:0] v;
    reg_wr(8'd11, 8'h42);
    pulse_tick();
    repeat (5) @(negedge clk);
    check("R10 irq held", {7'b0, irq}, 8'h01);
    bus_write(1'b0, 8'd12);
    tick_periodic = 1'b1; bus_re = 1'b1; bus_addr = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    tick_periodic = 1'b0; bus_re = 1'b0;
    check("R10 read before collision", v, 8'hC0);
    check("R10 irq kept after collision", {7'b0, irq}, 8'h01);
    bus_read(1'b1, v); check("R10 event kept for next read", v, 8'hC0);
    check("R10 irq cleared", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_ctl_outputs();
    reg_wr(8'd11, 8'h2D);
    check("R12 mode bits", {1'b0, per_ie, alm_ie, upd_ie, sqw_en, bin_mode, hr24, hold_set},
          8'b0010_1100);
  endtask

  task automatic t_reset_midrun();
    logic [7:0] v;
    reg_wr(8'd11, 8'h7A);
    pulse_tick();
    do_reset();
    check("R2 irq low after reset", {7'b0, irq}, 8'h00);
    reg_rd(8'd11, v); check("R2 mode after reset", v, 8'h02);
    reg_rd(8'd12, v); check("R2 flags after reset", v, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_reset_values();
    t_storage();
    t_ro_regs();
    t_uip();
    t_set_mode();
    t_update_irq();
    t_periodic();
    t_alarm();
    t_hold_and_collide();
    t_ctl_outputs();
    t_reset_midrun();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule